// File: doc/BRIEF.md
# Dual-Bank FM Synthesizer Register Decoder

This block sits between a host bus and the parameter storage of a two-bank FM synthesizer. The host first pulses an address strobe, which latches a register address and a bank select from the shared write bus. It then pulses a data strobe that carries the value. The block resolves that value into one of three kinds of result. An operator-field write names one of 36 operators. A channel-field write names one of 18 channels. A global register update covers the four-operator pair mask, the extended-mode enable and the second bank's special register. Each result is a single-cycle pulse with a decoded index, a field group code and the value to store.

For channel writes it also raises a frequency-recompute request, key-on and key-off events, and connection-recompute requests. Key events fire only when the key bit changes. In extended mode, a write to the upper half of an enabled four-operator pair is dropped. Reading returns a status byte supplied from outside. Envelope and tone generation live elsewhere.

The sequencer has two states. ST_IDLE means no usable address is latched. ST_ARMED means a nonzero address is latched. An address strobe with a nonzero value takes the arm transition from ST_IDLE to ST_ARMED. An address strobe with value 0 takes the disarm transition from ST_ARMED back to ST_IDLE. Every other cycle holds the state. Data strobes are acted on only in ST_ARMED. When both strobes arrive in the same cycle, the address strobe wins and the data strobe is dropped.

Top module: `fm_reg_decoder`

## Requirements
- R1: An address strobe latches `wr_data` as the address and `bank_sel` as the bank. A data strobe while the latched address is 0 (including straight after reset) produces no pulse and changes no global register.
- R2: An operator address is one in 0x20–0x9F or 0xE0–0xFF. Its slot s is the low 5 address bits. Slots 6, 7, 14, 15 and above 21 are dropped. Otherwise `op_sel` = s−4 for s≥16, s−2 for 8≤s<16, else s, plus 18 for bank 1. `op_grp` = address bits 7:5 (1,2,3,4,7) and `op_val` = data. All of these appear with `op_wr` the cycle after the data strobe.
- R3: For group 7 (waveform), `op_val` keeps data bits 2:0 when `ext_mode` is 1 and only bits 1:0 otherwise. The remaining bits are 0.
- R4: A channel address lies in 0xA0–0xDF with offset o = low 4 bits. Writes with o>8 are dropped, except address 0xBD, which gives `ch_wr` with `ch_grp`=4, `ch_sel`=9·bank and no other event. Group 0xD0 is dropped.
- R5: An accepted 0xAo, 0xBo or 0xCo write pulses `ch_wr` with `ch_grp` 1, 2 or 3, `ch_sel`=o+9·bank and `ch_val`=data. 0xAo and 0xBo writes also pulse `freq_req`.
- R6: For an accepted 0xBo write, `key_on` pulses when data bit 5 is 1 and the last stored key bit of that channel was 0. `key_off` pulses when data bit 5 is 0 and the stored bit was 1. A write with an unchanged bit gives no key event.
- R7: `key_four` and `freq_four` are 1 when `ext_mode` is 1, o<6, and pair mask bit (o mod 3)+3·bank is set.
- R8: With `ext_mode` 1, writes to 0xAo or 0xBo with o in 3..5 are dropped when pair mask bit (o−3)+3·bank is set. This covers key events and the stored key bit. 0xCo writes are not affected.
- R9: Bank 0 address 0x04 stores data bits 5:0 into `four_op_sel`. If `ext_mode` is 1 and the mask changes, `conn_req` pulses with `conn_mask` holding the changed bits. Every accepted 0xCo write pulses `conn_req` with `conn_mask`=0.
- R10: Bank 0 address 0x05 stores data bit 0 into `ext_mode`. Bank 1 address 0x08 stores the data into `special_reg`. All other addresses below 0x20 are dropped in either bank.
- R11: After reset all pulses, `four_op_sel`, `ext_mode`, `special_reg` and every stored key bit are 0.
- R12: `rd_data` combinationally equals `status_in` when `rd_port` is 0, and 0xFF when `rd_port` is 1.
- R13: Every event output is high for exactly one cycle per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Address strobe |
| data_wr | input | 1 | Data strobe |
| bank_sel | input | 1 | Bank with the address strobe |
| wr_data | input | 8 | Shared address/data bus |
| rd_port | input | 1 | Read port select |
| status_in | input | 8 | Status byte from timers |
| rd_data | output | 8 | Read data |
| op_wr | output | 1 | Operator field write pulse |
| op_sel | output | 6 | Operator index 0–35 |
| op_grp | output | 3 | Operator field group |
| op_val | output | 8 | Operator field value |
| ch_wr | output | 1 | Channel field write pulse |
| ch_sel | output | 5 | Channel index 0–17 |
| ch_grp | output | 3 | Channel field group |
| ch_val | output | 8 | Channel field value |
| freq_req | output | 1 | Frequency recompute pulse |
| freq_four | output | 1 | Recompute spans four operators |
| key_on | output | 1 | Key-on event |
| key_off | output | 1 | Key-off event |
| key_four | output | 1 | Key event spans four operators |
| conn_req | output | 1 | Connection recompute pulse |
| conn_mask | output | 6 | Pairs whose mode changed |
| four_op_sel | output | 6 | Four-operator pair mask |
| ext_mode | output | 1 | Extended mode enable |
| special_reg | output | 8 | Second-bank special register |

## Verification
Every pulse, index, group and value is registered once. It therefore shows in the cycle after the clock edge that samples the data strobe, and it is gone one cycle later. The global registers settle at that same edge. `rd_data` has no register and is valid in the cycle it is requested. The bench drives the strobes on falling edges. It samples on the falling edge right after the data strobe's rising edge, and once more a cycle later for pulse width.

// File: rtl/fm_reg_pkg.sv
package fm_reg_pkg;
    localparam int BANKS        = 2;
    localparam int CH_PER_BANK  = 9;
    localparam int OP_PER_BANK  = 18;
    localparam int PAIRS_PER_BK = 3;
    localparam int NUM_CH       = BANKS * CH_PER_BANK;
    localparam int NUM_PAIRS    = BANKS * PAIRS_PER_BK;
    localparam int CH_W         = $clog2(NUM_CH);
    localparam int OP_W         = $clog2(BANKS * OP_PER_BANK);

    typedef enum logic {ST_IDLE, ST_ARMED} seq_state_t;

    localparam logic [2:0] CG_FNUM_LO = 3'd1;
    localparam logic [2:0] CG_FNUM_HI = 3'd2;
    localparam logic [2:0] CG_ROUTE   = 3'd3;
    localparam logic [2:0] CG_PERC    = 3'd4;
endpackage

// File: rtl/fm_slot_map.sv
module fm_slot_map
    import fm_reg_pkg::*;
(
    input  logic [4:0]      slot,
    input  logic            bank,
    output logic            valid,
    output logic [OP_W-1:0] op_idx
);
    logic [4:0] packed_slot;

    always_comb begin
        valid = !(slot == 5'd6 || slot == 5'd7 || slot == 5'd14 ||
                  slot == 5'd15 || slot > 5'd21);
        if (slot >= 5'd16)      packed_slot = slot - 5'd4;
        else if (slot >= 5'd8)  packed_slot = slot - 5'd2;
        else                    packed_slot = slot;
        op_idx = {1'b0, packed_slot} + (bank ? OP_W'(OP_PER_BANK) : '0);
    end
endmodule

// File: rtl/fm_chan_decode.sv
module fm_chan_decode
    import fm_reg_pkg::*;
(
    input  logic [7:0]           addr,
    input  logic                 bank,
    input  logic                 ext_on,
    input  logic [NUM_PAIRS-1:0] pair_mask,
    output logic                 accept,
    output logic                 perc,
    output logic                 four,
    output logic [2:0]           grp,
    output logic [CH_W-1:0]      ch_idx
);
    logic [3:0] off;
    logic [3:0] off_mod;
    logic [2:0] pair_bit;
    logic [7:0] mask_wide;
    logic       blocked;

    always_comb begin
        off       = addr[3:0];
        off_mod   = (off > 4'd2) ? off - 4'd3 : off;
        pair_bit  = off_mod[2:0] + (bank ? 3'd3 : 3'd0);
        mask_wide = {{(8-NUM_PAIRS){1'b0}}, pair_mask};
        four      = ext_on && off < 4'd6 && mask_wide[pair_bit];
        perc      = addr == 8'hBD;
        blocked   = four && off > 4'd2 && addr < 8'hC0;
        unique case (addr[7:4])
            4'hA:    grp = CG_FNUM_LO;
            4'hB:    grp = CG_FNUM_HI;
            4'hC:    grp = CG_ROUTE;
            default: grp = 3'd0;
        endcase
        if (perc) grp = CG_PERC;
        accept = perc || (grp != 3'd0 && off <= 4'd8 && !blocked);
        ch_idx = perc ? '0 : CH_W'(off);
        if (bank) ch_idx = ch_idx + CH_W'(CH_PER_BANK);
    end
endmodule

// File: rtl/fm_key_track.sv
module fm_key_track
    import fm_reg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [CH_W-1:0] idx,
    input  logic            key_bit,
    output logic            changed
);
    logic [NUM_CH-1:0] held;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_key
        always_ff @(posedge clk) begin
            if (!rst_n)                            held[c] <= 1'b0;
            else if (upd && idx == CH_W'(c))       held[c] <= key_bit;
        end
    end

    always_comb begin
        changed = 1'b0;
        for (int c = 0; c < NUM_CH; c++)
            if (idx == CH_W'(c)) changed = key_bit != held[c];
    end
endmodule

// File: rtl/fm_reg_decoder.sv
module fm_reg_decoder
    import fm_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_wr,
    input  logic                 data_wr,
    input  logic                 bank_sel,
    input  logic [7:0]           wr_data,
    input  logic                 rd_port,
    input  logic [7:0]           status_in,
    output logic [7:0]           rd_data,
    output logic                 op_wr,
    output logic [OP_W-1:0]      op_sel,
    output logic [2:0]           op_grp,
    output logic [7:0]           op_val,
    output logic                 ch_wr,
    output logic [CH_W-1:0]      ch_sel,
    output logic [2:0]           ch_grp,
    output logic [7:0]           ch_val,
    output logic                 freq_req,
    output logic                 freq_four,
    output logic                 key_on,
    output logic                 key_off,
    output logic                 key_four,
    output logic                 conn_req,
    output logic [NUM_PAIRS-1:0] conn_mask,
    output logic [NUM_PAIRS-1:0] four_op_sel,
    output logic                 ext_mode,
    output logic [7:0]           special_reg
);
    seq_state_t state, state_nx;
    logic [7:0] lat_addr;
    logic       lat_bank;

    logic            do_wr, in_chan, in_op;
    logic            slot_ok;
    logic [OP_W-1:0] slot_op;
    logic            ch_ok, ch_perc, ch_four;
    logic [2:0]      ch_g;
    logic [CH_W-1:0] ch_i;
    logic            key_upd, key_chg;
    logic [NUM_PAIRS-1:0] mask_diff;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_addr <= 8'h00;
            lat_bank <= 1'b0;
        end else begin
            state <= state_nx;
            if (addr_wr) begin
                lat_addr <= wr_data;
                lat_bank <= bank_sel;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (addr_wr && wr_data != 8'h00) state_nx = ST_ARMED;
            ST_ARMED: if (addr_wr && wr_data == 8'h00) state_nx = ST_IDLE;
        endcase
    end

    assign do_wr   = data_wr && !addr_wr && state == ST_ARMED;
    assign in_chan = lat_addr >= 8'hA0 && lat_addr < 8'hE0;
    assign in_op   = lat_addr >= 8'h20 && !in_chan;

    fm_slot_map u_slot (
        .slot(lat_addr[4:0]), .bank(lat_bank), .valid(slot_ok), .op_idx(slot_op)
    );

    fm_chan_decode u_chan (
        .addr(lat_addr), .bank(lat_bank), .ext_on(ext_mode), .pair_mask(four_op_sel),
        .accept(ch_ok), .perc(ch_perc), .four(ch_four), .grp(ch_g), .ch_idx(ch_i)
    );

    assign key_upd   = do_wr && in_chan && ch_ok && !ch_perc && ch_g == CG_FNUM_HI;
    assign mask_diff = four_op_sel ^ wr_data[NUM_PAIRS-1:0];

    fm_key_track u_key (
        .clk(clk), .rst_n(rst_n), .upd(key_upd), .idx(ch_i),
        .key_bit(wr_data[5]), .changed(key_chg)
    );

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr <= 1'b0; op_sel <= '0; op_grp <= 3'd0; op_val <= 8'h00;
            ch_wr <= 1'b0; ch_sel <= '0; ch_grp <= 3'd0; ch_val <= 8'h00;
            freq_req <= 1'b0; freq_four <= 1'b0;
            key_on <= 1'b0; key_off <= 1'b0; key_four <= 1'b0;
            conn_req <= 1'b0; conn_mask <= '0;
            four_op_sel <= '0; ext_mode <= 1'b0; special_reg <= 8'h00;
        end else begin
            op_wr <= 1'b0; ch_wr <= 1'b0; freq_req <= 1'b0;
            key_on <= 1'b0; key_off <= 1'b0; conn_req <= 1'b0;
            if (do_wr && in_op && slot_ok) begin
                op_wr  <= 1'b1;
                op_sel <= slot_op;
                op_grp <= lat_addr[7:5];
                op_val <= wr_data;
                if (lat_addr[7:5] == 3'd7)
                    op_val <= {5'd0, wr_data[2] & ext_mode, wr_data[1:0]};
            end
            if (do_wr && in_chan && ch_ok) begin
                ch_wr  <= 1'b1;
                ch_sel <= ch_i;
                ch_grp <= ch_g;
                ch_val <= wr_data;
                if (!ch_perc && (ch_g == CG_FNUM_LO || ch_g == CG_FNUM_HI)) begin
                    freq_req  <= 1'b1;
                    freq_four <= ch_four;
                end
                if (key_upd && key_chg) begin
                    key_on   <= wr_data[5];
                    key_off  <= !wr_data[5];
                    key_four <= ch_four;
                end
                if (ch_g == CG_ROUTE) begin
                    conn_req  <= 1'b1;
                    conn_mask <= '0;
                end
            end
            if (do_wr && !in_op && !in_chan) begin
                if (!lat_bank && lat_addr == 8'h04) begin
                    four_op_sel <= wr_data[NUM_PAIRS-1:0];
                    if (ext_mode && mask_diff != '0) begin
                        conn_req  <= 1'b1;
                        conn_mask <= mask_diff;
                    end
                end
                if (!lat_bank && lat_addr == 8'h05) ext_mode <= wr_data[0];
                if (lat_bank && lat_addr == 8'h08)  special_reg <= wr_data;
            end
        end
    end

    assign rd_data = rd_port ? 8'hFF : status_in;
endmodule

// File: rtl/fm_reg_decoder_chk.sv
module fm_reg_decoder_chk
    import fm_reg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_wr,
    input logic                 data_wr,
    input logic [7:0]           lat_addr,
    input logic                 op_wr,
    input logic [OP_W-1:0]      op_sel,
    input logic [2:0]           op_grp,
    input logic [7:0]           op_val,
    input logic                 ch_wr,
    input logic [CH_W-1:0]      ch_sel,
    input logic [2:0]           ch_grp,
    input logic                 freq_req,
    input logic                 key_on,
    input logic                 key_off,
    input logic                 conn_req,
    input logic [NUM_PAIRS-1:0] four_op_sel,
    input logic                 ext_mode
);
    logic [CH_W-1:0] c_off;
    logic [2:0]      c_pair;
    logic [7:0]      c_mask;
    always_comb begin
        c_off  = (ch_sel >= CH_W'(CH_PER_BANK)) ? ch_sel - CH_W'(CH_PER_BANK) : ch_sel;
        c_pair = c_off[2:0] - 3'd3 + ((ch_sel >= CH_W'(CH_PER_BANK)) ? 3'd3 : 3'd0);
        c_mask = {{(8-NUM_PAIRS){1'b0}}, four_op_sel};
    end

    a_r1_zero_addr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && lat_addr == 8'h00) |=>
        !(op_wr || ch_wr || key_on || key_off || conn_req || freq_req));

    a_r2_op_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |-> op_sel < OP_W'(BANKS * OP_PER_BANK));

    a_r3_wave_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_grp == 3'd7 && !ext_mode) |-> op_val[7:2] == 6'd0);

    a_r6_key_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_on && key_off));

    a_r6_key_from_bx: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on || key_off) |-> (ch_wr && ch_grp == CG_FNUM_HI));

    a_r8_upper_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr && ext_mode && (ch_grp == CG_FNUM_LO || ch_grp == CG_FNUM_HI) &&
         c_off >= CH_W'(3) && c_off <= CH_W'(5)) |-> !c_mask[c_pair]);

    a_r13_key_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> !key_on);
endmodule

bind fm_reg_decoder fm_reg_decoder_chk u_chk (.*);

// File: tb/fm_reg_decoder_test.sv
module fm_reg_decoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_wr = 1'b0, data_wr = 1'b0, bank_sel = 1'b0, rd_port = 1'b0;
    logic [7:0] wr_data = 8'h00, status_in = 8'h00, rd_data;
    logic op_wr, ch_wr, freq_req, freq_four, key_on, key_off, key_four, conn_req, ext_mode;
    logic [5:0] op_sel, conn_mask, four_op_sel;
    logic [4:0] ch_sel;
    logic [2:0] op_grp, ch_grp;
    logic [7:0] op_val, ch_val, special_reg;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fm_reg_decoder uut (.*);

    // {bank, addr, data, exp_op, exp_ch, sel, grp, val}
    localparam int NV = 15;
    localparam logic [35:0] VECS [NV] = '{
        {1'b0, 8'h20, 8'h21, 1'b1, 1'b0, 6'd0,  3'd1, 8'h21},
        {1'b0, 8'h28, 8'h05, 1'b1, 1'b0, 6'd6,  3'd1, 8'h05},
        {1'b0, 8'h35, 8'h3F, 1'b1, 1'b0, 6'd17, 3'd1, 8'h3F},
        {1'b1, 8'h40, 8'h3F, 1'b1, 1'b0, 6'd18, 3'd2, 8'h3F},
        {1'b1, 8'h75, 8'hA5, 1'b1, 1'b0, 6'd35, 3'd3, 8'hA5},
        {1'b0, 8'h26, 8'h11, 1'b0, 1'b0, 6'd0,  3'd0, 8'h00},
        {1'b0, 8'h2F, 8'h11, 1'b0, 1'b0, 6'd0,  3'd0, 8'h00},
        {1'b0, 8'h36, 8'h11, 1'b0, 1'b0, 6'd0,  3'd0, 8'h00},
        {1'b0, 8'hE0, 8'hFF, 1'b1, 1'b0, 6'd0,  3'd7, 8'h03},
        {1'b0, 8'hA3, 8'h55, 1'b0, 1'b1, 6'd3,  3'd1, 8'h55},
        {1'b1, 8'hC8, 8'hF1, 1'b0, 1'b1, 6'd17, 3'd3, 8'hF1},
        {1'b0, 8'hA9, 8'h11, 1'b0, 1'b0, 6'd0,  3'd0, 8'h00},
        {1'b0, 8'hD0, 8'h11, 1'b0, 1'b0, 6'd0,  3'd0, 8'h00},
        {1'b0, 8'hBD, 8'hC0, 1'b0, 1'b1, 6'd0,  3'd4, 8'hC0},
        {1'b0, 8'h90, 8'h4F, 1'b1, 1'b0, 6'd12, 3'd4, 8'h4F}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // returns at the falling edge just after the data strobe was sampled
    task automatic wr(input bit bank, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr_wr = 1'b1; bank_sel = bank; wr_data = a;
        @(negedge clk); addr_wr = 1'b0; data_wr = 1'b1; wr_data = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    function automatic int events();
        return {op_wr, ch_wr, freq_req, key_on, key_off, conn_req};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        eq("R11", "events", events(), 0);
        eq("R11", "globals", {four_op_sel, ext_mode, special_reg}, 0);

        // R1 data strobe with nothing latched, then with address 0
        @(negedge clk); data_wr = 1'b1; wr_data = 8'hFF;
        @(negedge clk); data_wr = 1'b0;
        eq("R1", "events idle", events(), 0);
        wr(1'b0, 8'h00, 8'h01);
        eq("R1", "events addr0", events(), 0);
        eq("R1", "ext_mode addr0", ext_mode, 0);

        // R12 status read
        status_in = 8'h5A; rd_port = 1'b0; #1;
        eq("R12", "rd port0", rd_data, 8'h5A);
        rd_port = 1'b1; #1;
        eq("R12", "rd port1", rd_data, 8'hFF);
        rd_port = 1'b0;

        // R2 R3 R4 R5 table
        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VECS[i];
            wr(v[35], v[34:27], v[26:19]);
            eq("R2/R4 vec", $sformatf("op_wr[%0d]", i), op_wr, v[18]);
            eq("R4/R5 vec", $sformatf("ch_wr[%0d]", i), ch_wr, v[17]);
            if (v[18]) begin
                eq("R2", $sformatf("op_sel[%0d]", i), op_sel, v[16:11]);
                eq("R2", $sformatf("op_grp[%0d]", i), op_grp, v[10:8]);
                eq("R3", $sformatf("op_val[%0d]", i), op_val, v[7:0]);
            end
            if (v[17]) begin
                eq("R5", $sformatf("ch_sel[%0d]", i), ch_sel, v[16:11]);
                eq("R5", $sformatf("ch_grp[%0d]", i), ch_grp, v[10:8]);
                eq("R5", $sformatf("ch_val[%0d]", i), ch_val, v[7:0]);
            end
        end

        // R6 key edges on channel 2
        wr(1'b0, 8'hB2, 8'h20);
        eq("R6", "key_on rise", {key_on, key_off, key_four}, 3'b100);
        eq("R5", "freq_req on Bx", freq_req, 1);
        eq("R6", "key ch", ch_sel, 2);
        @(negedge clk);
        eq("R13", "pulses cleared", events(), 0);
        wr(1'b0, 8'hB2, 8'h21);
        eq("R6", "no key repeat", {key_on, key_off}, 0);
        eq("R6", "ch_wr on repeat", ch_wr, 1);
        wr(1'b0, 8'hB2, 8'h01);
        eq("R6", "key_off fall", {key_on, key_off}, 2'b01);
        wr(1'b0, 8'hB2, 8'h00);
        eq("R6", "no key off repeat", {key_on, key_off}, 0);

        // R10 global registers
        wr(1'b0, 8'h05, 8'h01);
        eq("R10", "ext_mode set", ext_mode, 1);
        wr(1'b0, 8'h04, 8'h09);
        eq("R9", "four_op_sel", four_op_sel, 6'h09);
        eq("R9", "conn_req mask", {conn_req, conn_mask}, {1'b1, 6'h09});
        wr(1'b1, 8'h08, 8'h40);
        eq("R10", "special", special_reg, 8'h40);
        wr(1'b1, 8'h05, 8'h00);
        eq("R10", "bank1 0x05 ignored", ext_mode, 1);
        wr(1'b0, 8'h08, 8'h77);
        eq("R10", "bank0 0x08 ignored", special_reg, 8'h40);
        wr(1'b1, 8'h04, 8'h00);
        eq("R10", "bank1 0x04 ignored", four_op_sel, 6'h09);

        // R3 waveform in extended mode
        wr(1'b0, 8'hE0, 8'hFF);
        eq("R3", "wave ext", op_val, 8'h07);

        // R7 four-operator key on channel 0 (pair bit 0)
        wr(1'b0, 8'hB0, 8'h20);
        eq("R7", "key four", {key_on, key_four, freq_four}, 3'b111);

        // R8 upper channel of enabled pair
        wr(1'b0, 8'hA3, 8'h11);
        eq("R8", "A3 blocked", events(), 0);
        wr(1'b0, 8'hB3, 8'h20);
        eq("R8", "B3 blocked", events(), 0);
        wr(1'b0, 8'hC3, 8'h01);
        eq("R8", "C3 accepted", {ch_wr, ch_sel, ch_grp}, {1'b1, 5'd3, 3'd3});
        eq("R9", "Cx conn", {conn_req, conn_mask}, {1'b1, 6'h00});
        wr(1'b1, 8'hA3, 8'h11);
        eq("R8", "bank1 A3 blocked", ch_wr, 0);
        wr(1'b1, 8'hA4, 8'h11);
        eq("R8", "bank1 A4 ok", {ch_wr, ch_sel, freq_four}, {1'b1, 5'd13, 1'b0});

        // R8 key bit untouched by blocked write: clear pair, then 0xB3 rises
        wr(1'b0, 8'h04, 8'h08);
        eq("R9", "change mask", {conn_req, conn_mask}, {1'b1, 6'h01});
        wr(1'b0, 8'h04, 8'h08);
        eq("R9", "no change", conn_req, 0);
        wr(1'b0, 8'hB3, 8'h20);
        eq("R8", "B3 key_on after unblock", key_on, 1);

        // R9 no connection request outside extended mode
        wr(1'b0, 8'h05, 8'h00);
        wr(1'b0, 8'h04, 8'h00);
        eq("R9", "no conn ext off", {conn_req, four_op_sel}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule